// File: doc/BRIEF.md
# Function-Unit Hazard Dependency Matrix

This block orders a set of function units (ALU units and load/store units alike) that share one register space. Each unit owns one row of a square matrix of 1-bit latches. When an instruction is issued to a unit, the issue logic supplies two vectors naming the other units that must finish first. One vector covers read-after-write: units whose results this instruction reads. The other covers write-after-write and program order: units that must write before this one may. The matrix turns those bits into per-unit read and write permissions.

A unit reads its operands once its read-side row is empty. It then executes and holds its result in its own buffer. It may write back only when its write-side row is empty and its write hold is low. The hold lets a unit keep its result back until an exception can be ruled out or a branch is resolved, so writes stay precise. A per-unit kill input discards work issued down a wrongly predicted path. When a unit writes back or is killed, its whole column is cleared at that edge, which releases every unit that was waiting on it.

Top module: `fu_hazard_matrix`

## Requirements
- R1: While reset (active low, synchronous) is asserted, and in the first cycle after it, every unit is idle: `unit_busy`, `go_read` and `go_write` are all zero when the inputs are zero.
- R2: An issue whose index selects an idle unit makes that unit busy from the next cycle. An issue to a busy unit is ignored: the unit's state and dependency bits do not change.
- R3: `go_read[i]` is high exactly when unit i is busy, has not yet read its operands, holds no read-after-write bit, and `go_die[i]` is low.
- R4: `go_write[i]` is high exactly when unit i has a buffered result, holds no write-after-write bit, has `wr_hold[i]` low, and has `go_die[i]` low.
- R5: While `wr_hold[i]` is high, unit i keeps its buffered result and `go_write[i]` stays low. Once the hold drops, the write is permitted with no further execution.
- R6: `wr_taken[i]` sampled together with `go_write[i]` makes unit i idle at the next edge. At the same edge it clears column i in every row.
- R7: `go_die[i]` on a busy unit makes it idle at the next edge and clears column i in every row. `go_die` on an idle unit has no effect.
- R8: At issue, a dependency bit is kept only for units that are busy and not releasing in that same cycle. A bit naming the issuing unit itself is dropped.
- R9: `rd_taken[i]` is ignored unless `go_read[i]` is high. `exec_done[i]` is ignored unless unit i has read its operands. `wr_taken[i]` is ignored unless `go_write[i]` is high.
- R10: A unit issued with a write-after-write bit on an older unit cannot obtain `go_write` before that older unit has written back, even when its own result is ready first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Issue request this cycle |
| issue_unit | input | IDX_W | Index of the unit receiving the instruction |
| issue_raw_dep | input | NUM_UNITS | Units whose results the new instruction reads |
| issue_waw_dep | input | NUM_UNITS | Units that must write back before the new instruction |
| rd_taken | input | NUM_UNITS | Unit has read its operands (honoured with go_read) |
| exec_done | input | NUM_UNITS | Unit has a result in its buffer |
| wr_hold | input | NUM_UNITS | Write prevention (exception or speculation pending) |
| wr_taken | input | NUM_UNITS | Unit writes back its result (honoured with go_write) |
| go_die | input | NUM_UNITS | Kill the unit's current instruction |
| go_read | output | NUM_UNITS | Permission to read operands |
| go_write | output | NUM_UNITS | Permission to write back the result |
| unit_busy | output | NUM_UNITS | Unit holds an instruction |

## Verification
A stuck dependency latch shows up at the ports as a `go_read` or `go_write` that never rises after the unit it names has written back or been killed, one cycle after that release. A latch that fails to capture at issue shows up as a permission that rises before the older unit finishes. A wrong unit state shows up as a permission that rises after an ignored strobe, or as `unit_busy` that does not fall the cycle after a write or kill. Every one of these differs from the expected vectors within one cycle of the stimulus that caused it, so the bench compares all three outputs in every cycle.

// File: rtl/fu_hazard_pkg.sv
// Package: shared types for the function-unit hazard matrix.
// Assumes: nothing beyond IEEE 1800-2017.
package fu_hazard_pkg;

    // Life cycle of one function unit's instruction.
    typedef enum logic [1:0] {
        UST_IDLE    = 2'd0,
        UST_WAIT_RD = 2'd1,
        UST_EXEC    = 2'd2,
        UST_RESULT  = 2'd3
    } unit_state_e;

endpackage

// File: rtl/fu_dep_row.sv
// Module: one matrix row holding the read-after-write and write-after-write
// latches of unit SELF against every unit.
// Assumes: incoming dependency vectors are already masked to live units;
// release_vec names units that write back or are killed this cycle.
module fu_dep_row #(
    parameter int NUM_UNITS = 4,
    parameter int SELF      = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 clr_row,
    input  logic [NUM_UNITS-1:0] raw_dep,
    input  logic [NUM_UNITS-1:0] waw_dep,
    input  logic [NUM_UNITS-1:0] release_vec,
    output logic                 raw_pend,
    output logic                 waw_pend
);

    localparam logic [NUM_UNITS-1:0] SELF_MASK = {{(NUM_UNITS-1){1'b0}}, 1'b1} << SELF;

    logic [NUM_UNITS-1:0] raw_q, waw_q;
    logic [NUM_UNITS-1:0] raw_d, waw_d;

    // Next latch contents: capture at issue, else drop released columns.
    always_comb begin
        raw_d = raw_q & ~release_vec;
        waw_d = waw_q & ~release_vec;
        if (clr_row) begin
            raw_d = '0;
            waw_d = '0;
        end
        if (load) begin
            raw_d = raw_dep & ~SELF_MASK;
            waw_d = waw_dep & ~SELF_MASK;
        end
    end

    // Latch storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
            waw_q <= '0;
        end else begin
            raw_q <= raw_d;
            waw_q <= waw_d;
        end
    end

    // Row summary used to block the unit.
    assign raw_pend = |raw_q;
    assign waw_pend = |waw_q;

    AST_NO_SELF_DEP: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!raw_q[SELF] && !waw_q[SELF])); // R8

    for (genvar c = 0; c < NUM_UNITS; c++) begin : g_col_chk
        AST_COLUMN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            release_vec[c] |=> (!raw_q[c] && !waw_q[c])); // R6
    end

endmodule

// File: rtl/fu_unit_ctl.sv
// Module: per-unit sequencer; tracks issue, operand read, buffered result
// and write-back, and derives the unit's permissions.
// Assumes: raw_pend/waw_pend come from the unit's own matrix row.
module fu_unit_ctl
    import fu_hazard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue_hit,
    input  logic raw_pend,
    input  logic waw_pend,
    input  logic rd_taken,
    input  logic exec_done,
    input  logic wr_hold,
    input  logic wr_taken,
    input  logic kill,
    output logic go_read,
    output logic go_write,
    output logic busy,
    output logic release_o
);

    unit_state_e state_q, state_d;

    // Permissions from current state and row summary.
    assign go_read   = (state_q == UST_WAIT_RD) && !raw_pend && !kill;
    assign go_write  = (state_q == UST_RESULT) && !waw_pend && !wr_hold && !kill;
    assign busy      = (state_q != UST_IDLE);
    assign release_o = busy && (kill || (wr_taken && go_write));

    // Next state; strobes count only when the matching permission holds.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UST_IDLE:    if (issue_hit) state_d = UST_WAIT_RD;
            UST_WAIT_RD: if (kill) state_d = UST_IDLE;
                         else if (rd_taken && go_read) state_d = UST_EXEC;
            UST_EXEC:    if (kill) state_d = UST_IDLE;
                         else if (exec_done) state_d = UST_RESULT;
            UST_RESULT:  if (kill) state_d = UST_IDLE;
                         else if (wr_taken && go_write) state_d = UST_IDLE;
            default:     state_d = UST_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UST_IDLE;
        else        state_q <= state_d;
    end

    AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_hit |=> busy); // R2
    AST_NO_DUAL_GO: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_read && go_write)); // R3
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hold |-> !go_write); // R5
    AST_WRITE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_taken && go_write) |=> !busy); // R6
    AST_KILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && busy) |=> !busy); // R7
    AST_EXEC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == UST_WAIT_RD && !(rd_taken && go_read)) |=> state_q != UST_EXEC); // R9

endmodule

// File: rtl/fu_hazard_matrix.sv
// Module: top of the function-unit hazard matrix. One sequencer and one
// latch row per unit; column release fans out to all rows.
// Assumes: NUM_UNITS >= 2; issue dependency vectors may name any unit,
// bits for idle or releasing units are dropped here.
module fu_hazard_matrix #(
    parameter int NUM_UNITS = 4,
    localparam int IDX_W    = $clog2(NUM_UNITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [IDX_W-1:0]     issue_unit,
    input  logic [NUM_UNITS-1:0] issue_raw_dep,
    input  logic [NUM_UNITS-1:0] issue_waw_dep,
    input  logic [NUM_UNITS-1:0] rd_taken,
    input  logic [NUM_UNITS-1:0] exec_done,
    input  logic [NUM_UNITS-1:0] wr_hold,
    input  logic [NUM_UNITS-1:0] wr_taken,
    input  logic [NUM_UNITS-1:0] go_die,
    output logic [NUM_UNITS-1:0] go_read,
    output logic [NUM_UNITS-1:0] go_write,
    output logic [NUM_UNITS-1:0] unit_busy
);

    logic [NUM_UNITS-1:0] release_vec;
    logic [NUM_UNITS-1:0] live_vec;
    logic [NUM_UNITS-1:0] issue_hit;
    logic [NUM_UNITS-1:0] raw_pend, waw_pend;
    logic [NUM_UNITS-1:0] raw_live, waw_live;

    // Only units that stay busy past this edge can be depended on.
    assign live_vec = unit_busy & ~release_vec;
    assign raw_live = issue_raw_dep & live_vec;
    assign waw_live = issue_waw_dep & live_vec;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        // Issue decode: accepted only by an idle unit.
        assign issue_hit[u] = issue_valid && (issue_unit == IDX_W'(u)) && !unit_busy[u];

        fu_dep_row #(
            .NUM_UNITS(NUM_UNITS),
            .SELF     (u)
        ) u_row (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (issue_hit[u]),
            .clr_row    (release_vec[u]),
            .raw_dep    (raw_live),
            .waw_dep    (waw_live),
            .release_vec(release_vec),
            .raw_pend   (raw_pend[u]),
            .waw_pend   (waw_pend[u])
        );

        fu_unit_ctl u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .issue_hit(issue_hit[u]),
            .raw_pend (raw_pend[u]),
            .waw_pend (waw_pend[u]),
            .rd_taken (rd_taken[u]),
            .exec_done(exec_done[u]),
            .wr_hold  (wr_hold[u]),
            .wr_taken (wr_taken[u]),
            .kill     (go_die[u]),
            .go_read  (go_read[u]),
            .go_write (go_write[u]),
            .busy     (unit_busy[u]),
            .release_o(release_vec[u])
        );
    end

    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_hit)); // R2
    AST_RELEASE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        ((release_vec & ~issue_hit) != '0) |=> ((unit_busy & $past(release_vec & ~issue_hit)) == '0)); // R7

endmodule

// File: tb/fu_hazard_matrix_tb_top.sv
module fu_hazard_matrix_tb_top;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 1'b0;
    logic [1:0] issue_unit = '0;
    logic [N-1:0] issue_raw_dep = '0, issue_waw_dep = '0;
    logic [N-1:0] rd_taken = '0, exec_done = '0, wr_hold = '0, wr_taken = '0, go_die = '0;
    logic [N-1:0] go_read, go_write, unit_busy;

    always #2 clk = ~clk; // 250 MHz

    fu_hazard_matrix #(.NUM_UNITS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_unit(issue_unit),
        .issue_raw_dep(issue_raw_dep), .issue_waw_dep(issue_waw_dep),
        .rd_taken(rd_taken), .exec_done(exec_done), .wr_hold(wr_hold),
        .wr_taken(wr_taken), .go_die(go_die),
        .go_read(go_read), .go_write(go_write), .unit_busy(unit_busy)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model: 0 idle, 1 wait read, 2 executing, 3 result buffered.
    int st[N];
    logic [N-1:0] rdm[N];
    logic [N-1:0] wrm[N];

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            st[i] = 0; rdm[i] = '0; wrm[i] = '0;
        end
    endtask

    function automatic logic [N-1:0] exp_gr(logic [N-1:0] kil);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = (st[i] == 1) && (rdm[i] == '0) && !kil[i];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_gw(logic [N-1:0] hold, logic [N-1:0] kil);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = (st[i] == 3) && (wrm[i] == '0) && !hold[i] && !kil[i];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_busy();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = (st[i] != 0);
        return r;
    endfunction

    // One cycle: drive at negedge, compare all outputs, advance the model.
    task automatic step(bit iv, bit [1:0] ifu, logic [N-1:0] rdd, logic [N-1:0] wrd,
                        logic [N-1:0] rdn, logic [N-1:0] exn, logic [N-1:0] wdn,
                        logic [N-1:0] hold, logic [N-1:0] kil);
        logic [N-1:0] gr, gw, bz, rel, live;
        bit iss;
        @(negedge clk);
        issue_valid = iv; issue_unit = ifu; issue_raw_dep = rdd; issue_waw_dep = wrd;
        rd_taken = rdn; exec_done = exn; wr_taken = wdn; wr_hold = hold; go_die = kil;
        #1;
        gr = exp_gr(kil); gw = exp_gw(hold, kil); bz = exp_busy();
        chk("R3 go_read", go_read, gr);
        chk("R4 go_write", go_write, gw);
        chk("R2 unit_busy", unit_busy, bz);
        for (int i = 0; i < N; i++) rel[i] = bz[i] && (kil[i] || (wdn[i] && gw[i]));
        live = bz & ~rel;
        iss = iv && (st[ifu] == 0);
        for (int i = 0; i < N; i++) begin
            if (iss && (i == int'(ifu))) begin
                rdm[i] = rdd & live; rdm[i][i] = 1'b0;
                wrm[i] = wrd & live; wrm[i][i] = 1'b0;
                st[i] = 1;
            end else begin
                if (rel[i]) begin rdm[i] = '0; wrm[i] = '0; end
                else begin rdm[i] &= ~rel; wrm[i] &= ~rel; end
                case (st[i])
                    1: if (kil[i]) st[i] = 0; else if (rdn[i] && gr[i]) st[i] = 2;
                    2: if (kil[i]) st[i] = 0; else if (exn[i]) st[i] = 3;
                    3: if (kil[i]) st[i] = 0; else if (wdn[i] && gw[i]) st[i] = 0;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic idle_step();
        step(0, 0, '0, '0, '0, '0, '0, '0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; issue_valid = 0; issue_raw_dep = '0; issue_waw_dep = '0;
        rd_taken = '0; exec_done = '0; wr_taken = '0; wr_hold = '0; go_die = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1 busy in reset", unit_busy, '0);
        chk("R1 go_read in reset", go_read, '0);
        chk("R1 go_write in reset", go_write, '0);
        model_clear();
        rst_n = 1;
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        model_clear();
        do_reset();
        idle_step();
        chk("R1 idle after reset", unit_busy, '0);

        // Directed: dependency, ignored re-issue, hold, release.
        step(1, 0, '0, '0, '0, '0, '0, '0, '0);
        step(1, 1, 4'b0001, 4'b0001, '0, '0, '0, '0, '0);
        chk("R3 fu0 may read", go_read, 4'b0001);
        step(1, 1, '0, '0, '0, '0, '0, '0, '0);
        chk("R8 fu1 blocked by fu0", go_read, 4'b0001);
        step(0, 0, '0, '0, 4'b0011, '0, '0, '0, '0);
        chk("R2 re-issue to busy fu1 ignored", go_read, 4'b0001);
        step(0, 0, '0, '0, '0, 4'b0011, '0, '0, '0);
        chk("R9 fu1 read strobe ignored", go_read, 4'b0000);
        step(0, 0, '0, '0, '0, '0, '0, 4'b0001, '0);
        chk("R5 hold blocks write", go_write, 4'b0000);
        step(0, 0, '0, '0, '0, '0, 4'b0001, 4'b0001, '0);
        chk("R9 write strobe ignored under hold", unit_busy, 4'b0011);
        step(0, 0, '0, '0, '0, '0, '0, '0, '0);
        chk("R5 write allowed after hold drops", go_write, 4'b0001);
        step(0, 0, '0, '0, '0, '0, 4'b0001, '0, '0);
        idle_step();
        chk("R6 fu0 idle after write", unit_busy, 4'b0010);
        chk("R6 fu1 released", go_read, 4'b0010);

        // Directed: kill releases dependents; kill of idle unit ignored.
        step(1, 3, '0, '0, '0, '0, '0, '0, '0);
        step(1, 2, 4'b1000, '0, '0, '0, '0, '0, '0);
        step(0, 0, '0, '0, '0, '0, '0, '0, 4'b0001);
        chk("R7 kill of idle unit", unit_busy, 4'b1110);
        chk("R7 fu2 still waits", go_read, 4'b1010);
        step(0, 0, '0, '0, '0, '0, '0, '0, 4'b1000);
        idle_step();
        chk("R7 fu3 idle after kill", unit_busy, 4'b0110);
        chk("R7 fu2 released by kill", go_read, 4'b0110);
        step(1, 0, 4'b0001, 4'b0001, '0, '0, '0, '0, '0);
        idle_step();
        chk("R8 self bit dropped", go_read, 4'b0111);

        // Directed: write order.
        do_reset();
        step(1, 0, '0, '0, '0, '0, '0, '0, '0);
        step(1, 1, '0, 4'b0001, '0, '0, '0, '0, '0);
        step(0, 0, '0, '0, 4'b0011, '0, '0, '0, '0);
        step(0, 0, '0, '0, '0, 4'b0011, '0, '0, '0);
        idle_step();
        chk("R10 younger waits for older", go_write, 4'b0001);
        step(0, 0, '0, '0, '0, '0, 4'b0001, '0, '0);
        idle_step();
        chk("R10 younger writes after older", go_write, 4'b0010);

        // Random phase, checked every cycle by the model.
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] kil;
            kil = ($urandom_range(15) == 0) ? (4'b0001 << $urandom_range(3)) : '0;
            step($urandom_range(1), 2'($urandom_range(3)), 4'($urandom), 4'($urandom),
                 4'($urandom), 4'($urandom), 4'($urandom),
                 4'($urandom) & 4'($urandom), kil);
        end
        do_reset();
        idle_step();
        chk("R1 idle after mid-run reset", unit_busy, '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule